// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

A single-port synchronous static memory model with a split representation of a shared data bus: `dq_in` carries data into the array, `dq_out` carries read data out, and `dq_oe` is the flag that says the memory would be driving the pins. An access begins on a rising clock edge when the clock is enabled, all three chip selects are active and the load strobe is low. The write strobe sampled on that edge fixes the access as a read or a write for the whole burst. Read data is not registered. It comes straight from the array during the cycle after the address edge, gated by an asynchronous output enable. Write data and the per-lane write enables are taken on the next enabled edge, and that same edge may also start a new access, so the block runs with no wait states.

Holding the load strobe high on later edges steps a 2-bit burst counter over the two lowest address bits, either linearly or interleaved. The counter wraps after four beats. The chip selects and the write strobe are ignored on those edges. A disabled clock freezes every register. A sleep request passes through a short entry and exit sequence. During that sequence and during sleep, accesses are refused and the bus is released, while the array keeps its contents.

Top module: `fts_sram`

## Requirements
- R1: After a synchronous reset (`rst_n` low over a clock edge), `dq_oe` is low and every word of the array reads as zero.
- R2: At a rising edge with `cke_n` high, nothing changes: the latched address, the burst position, the access type and any pending write are held, and read data on the bus stays the same.
- R3: An access starts at an edge where `cke_n`=0, `load_n`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. `wr_n`=0 makes it a write and `wr_n`=1 makes it a read.
- R4: For a read, `dq_out` shows the addressed word in the cycle after the address edge. `dq_oe` is high only while `out_en_n` is low, and it follows `out_en_n` without waiting for a clock edge.
- R5: In the cycle after a write address edge, `dq_oe` stays low whatever `out_en_n` is. `dq_in` is stored on the next enabled edge, and a read of the same word loaded on that edge returns the new data.
- R6: `lane_we_n[0]` low stores `dq_in[8:0]` and `lane_we_n[1]` low stores `dq_in[17:9]`. A lane whose bit is high keeps its old contents.
- R7: An enabled edge with `load_n`=1 during an access moves to the next burst beat whatever the chip selects and `wr_n` are, and it keeps the access type.
- R8: With `order_il`=0 at the load edge, beat n (n = 0..3) addresses the word whose low two bits are (start + n) mod 4. The upper address bits stay fixed.
- R9: With `order_il`=1 at the load edge, beat n addresses the word whose low two bits are start XOR n. The upper address bits stay fixed.
- R10: An enabled edge with `load_n`=0 and any chip select inactive ends the access, so `dq_oe` is low in the next cycle. Later edges with `load_n`=1 do not resume it.
- R11: `sleep_req` high at an edge refuses any access on that edge and drops any pending write. Entering sleep takes two more edges. If `sleep_req` is seen low at edge k while asleep, loads at edges k, k+1 and k+2 are refused, and a load at k+3 is accepted. Array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, active low |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| addr | input | AW | Word address |
| wr_n | input | 1 | Write strobe, low selects a write |
| load_n | input | 1 | Low loads a new address, high advances the burst |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep_req | input | 1 | Sleep request |
| dq_in | input | LANES*LW | Data into the array |
| dq_out | output | LANES*LW | Data out of the array (flow-through) |
| dq_oe | output | 1 | High when the memory drives the bus |

## Verification
Every word is first written by 4-beat burst writes that alternate between the two orders and use all four start offsets, so each word is reached by exactly one beat. Then all 64 words are read back under every combination of start offset and order. A wrong step in either order shows up as a word landing on, or being read from, the neighbour predicted by the other order. Directed patterns cover the remaining behaviour. Partial lane masks separate the two byte lanes. A write followed on its data edge by a read of the same word shows whether the commit and the new load share one edge. Stretches with the clock disabled and changing inputs show whether a read or a pending write is held. A deselect followed by an advance shows whether a finished burst is resumed. A pending write cut off by a sleep request, with loads issued at each edge of the exit sequence, shows whether the write is dropped and whether the block wakes on the right edge.

// File: rtl/fts_sram.sv
module fts_sram #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_n,
  input  logic             load_n,
  input  logic             order_il,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             out_en_n,
  input  logic             sleep_req,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {P_IDLE, P_RD, P_WR} phase_t;
  typedef enum logic [1:0] {S_RUN, S_IN, S_SLEEP, S_OUT} slp_t;

  phase_t        phase;
  slp_t          slp;
  logic          scnt;
  logic [AW-1:0] base;
  logic [1:0]    bcnt;
  logic          il_q;

  logic          go, awake, chip_on, start, desel, adv, commit;
  logic [1:0]    low;
  logic [AW-1:0] cur;

  assign go      = !cke_n;
  assign awake   = (slp == S_RUN) && !sleep_req;
  assign chip_on = !cs_a_n && cs_b && !cs_c_n;
  assign start   = go && awake && !load_n && chip_on;
  assign desel   = go && awake && !load_n && !chip_on;
  assign adv     = go && awake && load_n && (phase != P_IDLE);
  assign commit  = go && awake && (phase == P_WR);

  assign low = il_q ? (base[1:0] ^ bcnt) : (base[1:0] + bcnt);
  assign cur = {base[AW-1:2], low};

  assign dq_oe = (phase == P_RD) && !out_en_n && (slp == S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= P_IDLE;
      base  <= '0;
      bcnt  <= '0;
      il_q  <= 1'b0;
    end else if (!awake) begin
      phase <= P_IDLE;
    end else if (go) begin
      if (!load_n) begin
        if (chip_on) begin
          phase <= wr_n ? P_RD : P_WR;
          base  <= addr;
          bcnt  <= '0;
          il_q  <= order_il;
        end else begin
          phase <= P_IDLE;
        end
      end else if (phase != P_IDLE) begin
        bcnt <= bcnt + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slp  <= S_RUN;
      scnt <= 1'b0;
    end else begin
      case (slp)
        S_RUN: if (sleep_req) begin
          slp  <= S_IN;
          scnt <= 1'b0;
        end
        S_IN: if (scnt) begin
          slp  <= S_SLEEP;
          scnt <= 1'b0;
        end else scnt <= 1'b1;
        S_SLEEP: begin
          scnt <= 1'b0;
          if (!sleep_req) slp <= S_OUT;
        end
        default: if (scnt) begin
          slp  <= S_RUN;
          scnt <= 1'b0;
        end else scnt <= 1'b1;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
      end else if (commit && !lane_we_n[g]) begin
        arr[cur] <= dq_in[g*LW +: LW];
      end
    end

    assign dq_out[g*LW +: LW] = arr[cur];
  end

  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_n && awake) |=> ($stable(phase) && $stable(bcnt) && $stable(base)));

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((phase == ($past(wr_n) ? P_RD : P_WR)) && (base == $past(addr)) && (bcnt == 2'd0)));

  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_n) |=> !dq_oe);

  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ((bcnt == $past(bcnt) + 2'd1) && (phase == $past(phase))));

  a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !dq_oe);

  a_r11_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (slp != S_RUN) |=> (phase == P_IDLE));
endmodule

// File: tb/fts_sram_test.sv
`timescale 1ns/1ps
module fts_sram_test;
  logic        clk = 1'b0;
  logic        rst_n, cke_n, cs_a_n, cs_b, cs_c_n, wr_n, load_n, order_il;
  logic        out_en_n, sleep_req;
  logic [5:0]  addr;
  logic [1:0]  lane_we_n;
  logic [17:0] dq_in, dq_out;
  logic        dq_oe;

  int checks = 0;
  int fails  = 0;
  logic [17:0] model [64];

  fts_sram uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .addr(addr), .wr_n(wr_n), .load_n(load_n),
    .order_il(order_il), .lane_we_n(lane_we_n), .out_en_n(out_en_n),
    .sleep_req(sleep_req), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #10 clk = ~clk;

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 311 + salt * 97 + 13) ^ (a << 9));
  endfunction

  function automatic int baddr(input int b, input int n, input int il);
    int lo;
    lo = il ? ((b ^ n) & 3) : ((b + n) & 3);
    return (b & ~3) | lo;
  endfunction

  task automatic edge_();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_nop();
    cke_n = 0; load_n = 0; cs_a_n = 1; cs_b = 1; cs_c_n = 0;
    wr_n = 1; lane_we_n = 2'b11;
  endtask

  task automatic set_load(input int a, input bit w, input bit il);
    cke_n = 0; load_n = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    wr_n = w ? 1'b0 : 1'b1; addr = 6'(a); order_il = il;
  endtask

  task automatic set_adv();
    cke_n = 0; load_n = 1; cs_a_n = 1; cs_b = 0; wr_n = ~wr_n;
    addr = ~addr;
  endtask

  task automatic burst_write(input int b, input bit il, input int salt);
    set_load(b, 1, il);
    edge_();
    for (int n = 0; n < 4; n++) begin
      if (n < 3) set_adv(); else set_nop();
      dq_in = pat(baddr(b, n, il), salt);
      lane_we_n = 2'b00;
      edge_();
      model[baddr(b, n, il)] = pat(baddr(b, n, il), salt);
    end
    lane_we_n = 2'b11;
  endtask

  task automatic burst_read(input int b, input bit il, input string tag);
    set_load(b, 0, il);
    out_en_n = 0;
    edge_();
    for (int n = 0; n < 4; n++) begin
      if (n < 3) set_adv(); else set_nop();
      #1;
      chk(tag, {dq_oe, dq_out}, {1'b1, model[baddr(b, n, il)]});
      edge_();
    end
  endtask

  task automatic single_write(input int a, input logic [17:0] d, input logic [1:0] lanes);
    set_load(a, 1, 0);
    edge_();
    set_nop();
    dq_in = d;
    lane_we_n = lanes;
    edge_();
    if (!lanes[0]) model[a][8:0]  = d[8:0];
    if (!lanes[1]) model[a][17:9] = d[17:9];
    lane_we_n = 2'b11;
  endtask

  task automatic single_read(input int a, input string tag);
    set_load(a, 0, 0);
    out_en_n = 0;
    edge_();
    set_nop();
    #1;
    chk(tag, {dq_oe, dq_out}, {1'b1, model[a]});
    edge_();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = '0;
    rst_n = 0; sleep_req = 0; out_en_n = 0; order_il = 0; addr = '0; dq_in = '0;
    set_nop();
    repeat (3) edge_();
    rst_n = 1;
    #1;
    chk("R1 bus idle after reset", {18'd0, dq_oe}, 19'd0);
    edge_();
    burst_read(5, 0, "R1 zero contents");

    for (int g = 0; g < 16; g++) burst_write(g * 4 + (g % 4), bit'(g & 1), 1);
    for (int g = 0; g < 16; g++)
      for (int il = 0; il < 2; il++)
        for (int s = 0; s < 4; s++)
          burst_read(g * 4 + s, bit'(il), il ? "R9 interleaved R7 R3" : "R8 linear R7 R3");

    set_load(7, 0, 0);
    edge_();
    set_nop();
    out_en_n = 1;
    #1;
    chk("R4 oe high releases bus", {18'd0, dq_oe}, 19'd0);
    out_en_n = 0;
    #1;
    chk("R4 oe low drives data", {dq_oe, dq_out}, {1'b1, model[7]});
    edge_();

    set_load(9, 1, 0);
    edge_();
    out_en_n = 0;
    #1;
    chk("R5 write cycle not driven", {18'd0, dq_oe}, 19'd0);
    set_load(9, 0, 0);
    dq_in = pat(9, 5);
    lane_we_n = 2'b00;
    edge_();
    model[9] = pat(9, 5);
    set_nop();
    #1;
    chk("R5 read after write same edge", {dq_oe, dq_out}, {1'b1, model[9]});
    edge_();

    single_write(12, 18'h2A5A5, 2'b10);
    single_read(12, "R6 lane0 only");
    single_write(12, 18'h15C3C, 2'b01);
    single_read(12, "R6 lane1 only");
    single_write(12, 18'h3FFFF, 2'b11);
    single_read(12, "R6 no lanes");

    set_load(20, 0, 0);
    edge_();
    set_load(33, 1, 1);
    cke_n = 1;
    for (int i = 0; i < 3; i++) begin
      edge_();
      #1;
      chk("R2 read held", {dq_oe, dq_out}, {1'b1, model[20]});
    end
    cke_n = 0;
    load_n = 1;
    edge_();
    set_nop();
    #1;
    chk("R2 burst resumes at next beat", {dq_oe, dq_out}, {1'b1, model[21]});
    edge_();

    set_load(40, 1, 0);
    edge_();
    set_load(41, 0, 0);
    cke_n = 1;
    dq_in = 18'h00BAD;
    lane_we_n = 2'b00;
    repeat (2) edge_();
    set_nop();
    lane_we_n = 2'b00;
    dq_in = pat(40, 9);
    edge_();
    model[40] = pat(40, 9);
    lane_we_n = 2'b11;
    single_read(40, "R2 pending write held");
    single_read(41, "R2 frozen edge wrote nothing");

    set_load(3, 0, 0);
    edge_();
    set_nop();
    #1;
    chk("R10 read before deselect", {dq_oe, dq_out}, {1'b1, model[3]});
    edge_();
    #1;
    chk("R10 deselect releases bus", {18'd0, dq_oe}, 19'd0);
    set_adv();
    edge_();
    #1;
    chk("R10 advance after deselect", {18'd0, dq_oe}, 19'd0);
    set_nop();
    edge_();

    set_load(50, 1, 0);
    edge_();
    set_nop();
    dq_in = 18'h1DEAD;
    lane_we_n = 2'b00;
    sleep_req = 1;
    edge_();
    lane_we_n = 2'b11;
    #1;
    chk("R11 bus released at entry", {18'd0, dq_oe}, 19'd0);
    set_load(50, 0, 0);
    repeat (4) edge_();
    #1;
    chk("R11 load refused asleep", {18'd0, dq_oe}, 19'd0);
    sleep_req = 0;
    for (int i = 0; i < 4; i++) begin
      set_load(50, 0, 0);
      edge_();
      set_nop();
      #1;
      chk("R11 exit sequence", {18'd0, dq_oe}, {18'd0, (i == 3)});
    end
    chk("R11 dropped write and kept data", {dq_oe, dq_out}, {1'b1, model[50]});
    edge_();
    single_read(17, "R11 contents kept");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule